// File: doc/BRIEF.md
# TLB Maintenance Register Block

This block gives software a register-level window onto the entries of a set-associative translation buffer. It holds three control registers: an entry-attribute register, a control/context register and a page-entry pointer register. Software writes them over a simple control-register bus. Some of those writes start a one-cycle request on the maintenance port of the TLB storage. A request either stores one entry or fetches one entry back.

Every register has two views. The last-written copy feeds the TLB requests. The read-back copy is what the bus returns. A write to the attribute register installs an entry and leaves the attribute read-back untouched. An entry fetch overwrites the read-back of all three registers at once.

After every installed entry, the way pointer advances by itself, so successive writes fill the ways in turn. The block also drives the current address-space identifier, taken from the last-written control register, to the translation lookup path.

Top module: `tlb_ctl_regs`

## Requirements
- R1: After synchronous reset, all three read-backs and the current identifier are zero and no TLB request is active. Read select 0 returns the attribute read-back, 1 returns the control read-back, 2 returns the pointer read-back and 3 returns zero.
- R2: Writing the attribute register (select 0) while bit 18 of the control read-back is set raises `tlb_wr_en` for exactly the next cycle. The request carries the following fields:
  - way: control read-back bits [20 +: WAY_W], taken before the write;
  - page number: last-written pointer bits [21:2];
  - index: the low IDX_W bits of that page number;
  - identifier: last-written control bits [4 +: PID_W];
  - global flag: bit 24 of the written value;
  - data word: bits [23:0] of the written value.
- R3: Each installed entry advances the control read-back way field [20 +: WAY_W] by one, modulo NUM_WAYS.
- R4: Writing the attribute register while control read-back bit 18 is clear issues no TLB request and leaves the way field unchanged.
- R5: A write to the attribute register never changes the attribute read-back.
- R6: Writing the control register (select 1) with bit 19 set raises `tlb_rd_en` for exactly the next cycle. The request uses the way in bits [20 +: WAY_W] of the written value and the index from the last-written page number.
- R7: In the cycle after `tlb_rd_valid`, the attribute read-back is formed from three parts:
  - its own previous bits [31:25];
  - the returned data word in bits [23:0];
  - the returned global flag in bit 24.
- R8: In the cycle after `tlb_rd_valid`, the control read-back equals the last-written control value with bits [4 +: PID_W] replaced by the returned identifier. The pointer read-back has bits [21:2] replaced by the returned page number.
- R9: A control write with bit 19 clear copies the written value to the control read-back on the next cycle. Every control write, with or without bit 19, updates the current identifier output to the written bits [4 +: PID_W].
- R10: A pointer write (select 2) replaces every read-back pointer bit except [21:2], which keep their old value. Later TLB requests use the new page number.
- R11: `tlb_wr_en` and `tlb_rd_en` are never high together, and each bus write starts at most one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| creg_we | input | 1 | Register write strobe |
| creg_wsel | input | 2 | Register targeted by the write |
| creg_wdata | input | 32 | Write value |
| creg_rsel | input | 2 | Register whose read-back is returned |
| creg_rdata | output | 32 | Read-back value (combinational) |
| cur_pid | output | PID_W | Current address-space identifier for lookups |
| tlb_wr_en | output | 1 | Entry install request |
| tlb_wr_way | output | WAY_W | Way to install into |
| tlb_wr_idx | output | IDX_W | Set index to install into |
| tlb_wr_vpn | output | 20 | Virtual page number of the new entry |
| tlb_wr_pid | output | PID_W | Identifier of the new entry |
| tlb_wr_glob | output | 1 | Global flag of the new entry |
| tlb_wr_data | output | 24 | Data word of the new entry |
| tlb_rd_en | output | 1 | Entry fetch request |
| tlb_rd_way | output | WAY_W | Way to fetch |
| tlb_rd_idx | output | IDX_W | Set index to fetch |
| tlb_rd_valid | input | 1 | Fetched entry is present this cycle |
| tlb_rd_vpn | input | 20 | Fetched page number |
| tlb_rd_pid | input | PID_W | Fetched identifier |
| tlb_rd_glob | input | 1 | Fetched global flag |
| tlb_rd_data | input | 24 | Fetched data word |

## Verification
The bench builds the block with NUM_WAYS=4 and NUM_ENTRIES=32, which gives eight sets, a two-bit way field and a three-bit index. Those values let four consecutive installs carry the way pointer through its wrap back to zero. They also make several page numbers land on distinct sets, which exposes any wrong index extraction. A small storage model in the bench answers fetches one cycle after the request. It returns whatever the design actually installed, so a fetched entry shows what the write path really stored.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        SEL_ATTR = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_NONE = 2'd3
    } creg_sel_e;

    // attribute register layout
    localparam int DATA_W       = 24;   // cache/read/write/exec flags + frame number
    localparam int ATTR_GLOB    = 24;
    localparam int ATTR_KEEP_LO = 25;   // bits above this are retained on a fetch
    localparam int ATTR_LW_W    = 25;

    // control register layout
    localparam int CTRL_PID_LSB = 4;
    localparam int CTRL_WE_BIT  = 18;
    localparam int CTRL_RD_BIT  = 19;
    localparam int CTRL_WAY_LSB = 20;

    // pointer register layout
    localparam int PTR_VPN_LSB  = 2;
    localparam int VPN_W        = 20;

    function automatic logic [DW-1:0] keep_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int b = ATTR_KEEP_LO; b < DW; b++) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [VPN_W-1:0] vpn_of(input logic [DW-1:0] ptr);
        return ptr[PTR_VPN_LSB +: VPN_W];
    endfunction

    function automatic logic [DW-1:0] with_vpn(input logic [DW-1:0] ptr,
                                               input logic [VPN_W-1:0] vpn);
        logic [DW-1:0] r;
        r = ptr;
        r[PTR_VPN_LSB +: VPN_W] = vpn;
        return r;
    endfunction

endpackage

// File: rtl/tlbc_shadow.sv
module tlbc_shadow
    import tlbc_pkg::*;
#(
    parameter int PID_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  creg_sel_e            wsel,
    input  logic [DW-1:0]        wdata,
    output logic [ATTR_LW_W-1:0] attr_lw,
    output logic [DW-1:0]        ctrl_lw,
    output logic [VPN_W-1:0]     vpn_lw,
    output logic [PID_W-1:0]     pid_lw
);

    always_ff @(posedge clk) begin
        if (rst) begin
            attr_lw <= '0;
            ctrl_lw <= '0;
            vpn_lw  <= '0;
        end else if (we) begin
            case (wsel)
                SEL_ATTR: attr_lw <= wdata[ATTR_LW_W-1:0];
                SEL_CTRL: ctrl_lw <= wdata;
                SEL_PTR:  vpn_lw  <= vpn_of(wdata);
                default:  ;
            endcase
        end
    end

    assign pid_lw = ctrl_lw[CTRL_PID_LSB +: PID_W];

endmodule

// File: rtl/tlbc_cmd.sv
module tlbc_cmd
    import tlbc_pkg::*;
#(
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  creg_sel_e        wsel,
    input  logic [DW-1:0]    wdata,
    input  logic             rb_we_bit,
    input  logic [WAY_W-1:0] rb_way,
    output logic             wr_en,
    output logic [WAY_W-1:0] wr_way,
    output logic             rd_en,
    output logic [WAY_W-1:0] rd_way
);

    logic start_wr, start_rd;

    always_comb begin
        start_wr = we && (wsel == SEL_ATTR) && rb_we_bit;
        start_rd = we && (wsel == SEL_CTRL) && wdata[CTRL_RD_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en  <= 1'b0;
            rd_en  <= 1'b0;
            wr_way <= '0;
            rd_way <= '0;
        end else begin
            wr_en <= start_wr;
            rd_en <= start_rd;
            if (start_wr) wr_way <= rb_way;
            if (start_rd) rd_way <= wdata[CTRL_WAY_LSB +: WAY_W];
        end
    end

endmodule

// File: rtl/tlbc_readback.sv
module tlbc_readback
    import tlbc_pkg::*;
#(
    parameter int WAY_W = 2,
    parameter int PID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  creg_sel_e         wsel,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     ctrl_lw,
    input  logic              fetch_valid,
    input  logic [VPN_W-1:0]  fetch_vpn,
    input  logic [PID_W-1:0]  fetch_pid,
    input  logic              fetch_glob,
    input  logic [DATA_W-1:0] fetch_data,
    output logic [DW-1:0]     attr_rb,
    output logic [DW-1:0]     ctrl_rb,
    output logic [DW-1:0]     ptr_rb
);

    localparam logic [DW-1:0] KEEP = keep_mask();

    logic [WAY_W-1:0] way_next;
    logic [DW-1:0]    attr_fetch, ctrl_fetch;

    always_comb begin
        way_next   = ctrl_rb[CTRL_WAY_LSB +: WAY_W] + WAY_W'(1);
        attr_fetch = (attr_rb & KEEP) | DW'(fetch_data);
        attr_fetch[ATTR_GLOB] = fetch_glob;
        ctrl_fetch = ctrl_lw;
        ctrl_fetch[CTRL_PID_LSB +: PID_W] = fetch_pid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attr_rb <= '0;
            ctrl_rb <= '0;
            ptr_rb  <= '0;
        end else if (fetch_valid) begin
            attr_rb <= attr_fetch;
            ctrl_rb <= ctrl_fetch;
            ptr_rb  <= with_vpn(ptr_rb, fetch_vpn);
        end else if (we) begin
            case (wsel)
                SEL_ATTR: if (ctrl_rb[CTRL_WE_BIT])
                              ctrl_rb[CTRL_WAY_LSB +: WAY_W] <= way_next;
                SEL_CTRL: if (!wdata[CTRL_RD_BIT]) ctrl_rb <= wdata;
                SEL_PTR:  ptr_rb <= with_vpn(wdata, vpn_of(ptr_rb));
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/tlb_ctl_regs.sv
module tlb_ctl_regs
    import tlbc_pkg::*;
#(
    parameter int NUM_WAYS    = 16,
    parameter int NUM_ENTRIES = 128,
    parameter int PID_W       = 8,
    localparam int WAY_W      = $clog2(NUM_WAYS),
    localparam int IDX_W      = $clog2(NUM_ENTRIES / NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              creg_we,
    input  logic [1:0]        creg_wsel,
    input  logic [31:0]       creg_wdata,
    input  logic [1:0]        creg_rsel,
    output logic [31:0]       creg_rdata,
    output logic [PID_W-1:0]  cur_pid,
    output logic              tlb_wr_en,
    output logic [WAY_W-1:0]  tlb_wr_way,
    output logic [IDX_W-1:0]  tlb_wr_idx,
    output logic [19:0]       tlb_wr_vpn,
    output logic [PID_W-1:0]  tlb_wr_pid,
    output logic              tlb_wr_glob,
    output logic [23:0]       tlb_wr_data,
    output logic              tlb_rd_en,
    output logic [WAY_W-1:0]  tlb_rd_way,
    output logic [IDX_W-1:0]  tlb_rd_idx,
    input  logic              tlb_rd_valid,
    input  logic [19:0]       tlb_rd_vpn,
    input  logic [PID_W-1:0]  tlb_rd_pid,
    input  logic              tlb_rd_glob,
    input  logic [23:0]       tlb_rd_data
);

    creg_sel_e              wsel;
    logic [ATTR_LW_W-1:0]   attr_lw;
    logic [DW-1:0]          ctrl_lw;
    logic [VPN_W-1:0]       vpn_lw;
    logic [PID_W-1:0]       pid_lw;
    logic [DW-1:0]          attr_rb, ctrl_rb, ptr_rb;

    assign wsel = creg_sel_e'(creg_wsel);

    tlbc_shadow #(.PID_W(PID_W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .we      (creg_we),
        .wsel    (wsel),
        .wdata   (creg_wdata),
        .attr_lw (attr_lw),
        .ctrl_lw (ctrl_lw),
        .vpn_lw  (vpn_lw),
        .pid_lw  (pid_lw)
    );

    tlbc_cmd #(.WAY_W(WAY_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .we        (creg_we),
        .wsel      (wsel),
        .wdata     (creg_wdata),
        .rb_we_bit (ctrl_rb[CTRL_WE_BIT]),
        .rb_way    (ctrl_rb[CTRL_WAY_LSB +: WAY_W]),
        .wr_en     (tlb_wr_en),
        .wr_way    (tlb_wr_way),
        .rd_en     (tlb_rd_en),
        .rd_way    (tlb_rd_way)
    );

    tlbc_readback #(.WAY_W(WAY_W), .PID_W(PID_W)) u_rb (
        .clk         (clk),
        .rst         (rst),
        .we          (creg_we),
        .wsel        (wsel),
        .wdata       (creg_wdata),
        .ctrl_lw     (ctrl_lw),
        .fetch_valid (tlb_rd_valid),
        .fetch_vpn   (tlb_rd_vpn),
        .fetch_pid   (tlb_rd_pid),
        .fetch_glob  (tlb_rd_glob),
        .fetch_data  (tlb_rd_data),
        .attr_rb     (attr_rb),
        .ctrl_rb     (ctrl_rb),
        .ptr_rb      (ptr_rb)
    );

    // entry payload comes from the last-written copies, loaded on the same edge as the request
    assign tlb_wr_vpn  = vpn_lw;
    assign tlb_wr_idx  = vpn_lw[IDX_W-1:0];
    assign tlb_wr_pid  = pid_lw;
    assign tlb_wr_glob = attr_lw[ATTR_GLOB];
    assign tlb_wr_data = attr_lw[DATA_W-1:0];
    assign tlb_rd_idx  = vpn_lw[IDX_W-1:0];
    assign cur_pid     = pid_lw;

    always_comb begin
        case (creg_sel_e'(creg_rsel))
            SEL_ATTR: creg_rdata = attr_rb;
            SEL_CTRL: creg_rdata = ctrl_rb;
            SEL_PTR:  creg_rdata = ptr_rb;
            default:  creg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tlbc_checker.sv
module tlbc_checker #(
    parameter int WAY_W = 2,
    parameter int PID_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             creg_we,
    input logic [1:0]       creg_wsel,
    input logic [31:0]      creg_wdata,
    input logic             tlb_wr_en,
    input logic [WAY_W-1:0] tlb_wr_way,
    input logic             tlb_rd_en,
    input logic             tlb_rd_valid,
    input logic [31:0]      attr_rb,
    input logic [WAY_W-1:0] rb_way,
    input logic [PID_W-1:0] cur_pid
);

    assert_one_op_R11: assert property (@(posedge clk) disable iff (rst)
        !(tlb_wr_en && tlb_rd_en));

    assert_wr_cause_R2: assert property (@(posedge clk) disable iff (rst)
        tlb_wr_en |-> $past(creg_we && creg_wsel == 2'd0));

    assert_rd_cause_R6: assert property (@(posedge clk) disable iff (rst)
        tlb_rd_en |-> $past(creg_we && creg_wsel == 2'd1 && creg_wdata[19]));

    assert_way_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tlb_wr_en && !$past(tlb_rd_valid)) |-> (rb_way == WAY_W'(tlb_wr_way + 1'b1)));

    assert_attr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(tlb_rd_valid) |-> $stable(attr_rb));

    assert_pid_source_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(creg_we && creg_wsel == 2'd1) |-> $stable(cur_pid));

endmodule

bind tlb_ctl_regs tlbc_checker #(.WAY_W(WAY_W), .PID_W(PID_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .creg_we      (creg_we),
    .creg_wsel    (creg_wsel),
    .creg_wdata   (creg_wdata),
    .tlb_wr_en    (tlb_wr_en),
    .tlb_wr_way   (tlb_wr_way),
    .tlb_rd_en    (tlb_rd_en),
    .tlb_rd_valid (tlb_rd_valid),
    .attr_rb      (attr_rb),
    .rb_way       (ctrl_rb[20 +: WAY_W]),
    .cur_pid      (cur_pid)
);

// File: tb/test_tlb_ctl_regs.sv
module test_tlb_ctl_regs;

    localparam int NW = 4;
    localparam int NE = 32;
    localparam int NS = NE / NW;
    localparam int WW = 2;
    localparam int IW = 3;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic creg_we = 1'b0;
    logic [1:0] creg_wsel = 2'd0;
    logic [31:0] creg_wdata = '0;
    logic [1:0] creg_rsel = 2'd0;
    logic [31:0] creg_rdata;
    logic [PW-1:0] cur_pid;
    logic tlb_wr_en, tlb_wr_glob, tlb_rd_en;
    logic [WW-1:0] tlb_wr_way, tlb_rd_way;
    logic [IW-1:0] tlb_wr_idx, tlb_rd_idx;
    logic [19:0] tlb_wr_vpn;
    logic [PW-1:0] tlb_wr_pid;
    logic [23:0] tlb_wr_data;
    logic tlb_rd_valid = 1'b0;
    logic [19:0] tlb_rd_vpn = '0;
    logic [PW-1:0] tlb_rd_pid = '0;
    logic tlb_rd_glob = 1'b0;
    logic [23:0] tlb_rd_data = '0;

    always #2.5 clk = ~clk;

    tlb_ctl_regs #(.NUM_WAYS(NW), .NUM_ENTRIES(NE), .PID_W(PW)) i_tlb_ctl_regs (
        .clk(clk), .rst(rst), .creg_we(creg_we), .creg_wsel(creg_wsel),
        .creg_wdata(creg_wdata), .creg_rsel(creg_rsel), .creg_rdata(creg_rdata),
        .cur_pid(cur_pid), .tlb_wr_en(tlb_wr_en), .tlb_wr_way(tlb_wr_way),
        .tlb_wr_idx(tlb_wr_idx), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_pid(tlb_wr_pid),
        .tlb_wr_glob(tlb_wr_glob), .tlb_wr_data(tlb_wr_data), .tlb_rd_en(tlb_rd_en),
        .tlb_rd_way(tlb_rd_way), .tlb_rd_idx(tlb_rd_idx), .tlb_rd_valid(tlb_rd_valid),
        .tlb_rd_vpn(tlb_rd_vpn), .tlb_rd_pid(tlb_rd_pid), .tlb_rd_glob(tlb_rd_glob),
        .tlb_rd_data(tlb_rd_data)
    );

    // storage stub: stores what the design sends, answers a fetch one cycle later
    logic [19:0]   s_vpn  [NW][NS];
    logic [PW-1:0] s_pid  [NW][NS];
    logic          s_glob [NW][NS];
    logic [23:0]   s_data [NW][NS];

    always @(posedge clk) begin
        if (tlb_wr_en) begin
            s_vpn[tlb_wr_way][tlb_wr_idx]  <= tlb_wr_vpn;
            s_pid[tlb_wr_way][tlb_wr_idx]  <= tlb_wr_pid;
            s_glob[tlb_wr_way][tlb_wr_idx] <= tlb_wr_glob;
            s_data[tlb_wr_way][tlb_wr_idx] <= tlb_wr_data;
        end
        tlb_rd_valid <= tlb_rd_en && !rst;
        if (tlb_rd_en) begin
            tlb_rd_vpn  <= s_vpn[tlb_rd_way][tlb_rd_idx];
            tlb_rd_pid  <= s_pid[tlb_rd_way][tlb_rd_idx];
            tlb_rd_glob <= s_glob[tlb_rd_way][tlb_rd_idx];
            tlb_rd_data <= s_data[tlb_rd_way][tlb_rd_idx];
        end
    end

    // reference model
    int unsigned m_vpn  [NW][NS];
    int unsigned m_pid  [NW][NS];
    int unsigned m_glob [NW][NS];
    int unsigned m_data [NW][NS];
    int unsigned e_attr_rb = 0, e_ctrl_rb = 0, e_ptr_rb = 0;
    int unsigned e_ctrl_lw = 0, e_vpn_lw = 0;
    bit e_wr = 0, e_rd = 0;
    int unsigned e_wway, e_widx, e_wvpn, e_wpid, e_wglob, e_wdata, e_rway, e_ridx;
    int checks = 0, errors = 0;
    bit run = 0;

    task automatic check(input string req, input string what,
                         input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int unsigned exp_rdata(input int sel);
        case (sel)
            0: return e_attr_rb;
            1: return e_ctrl_rb;
            2: return e_ptr_rb;
            default: return 0;
        endcase
    endfunction

    // compared on every clock
    always @(negedge clk) begin
        if (run && !rst) begin
            check("R11", "wr_en", tlb_wr_en, e_wr);
            check("R6", "rd_en", tlb_rd_en, e_rd);
            check("R9", "cur_pid", cur_pid, (e_ctrl_lw >> 4) & 8'hFF);
            case (creg_rsel)
                2'd0: check("R5 R7", "attr readback", creg_rdata, exp_rdata(0));
                2'd1: check("R8 R9", "ctrl readback", creg_rdata, exp_rdata(1));
                2'd2: check("R10", "ptr readback", creg_rdata, exp_rdata(2));
                default: check("R1", "empty select", creg_rdata, 0);
            endcase
            if (e_wr) begin
                check("R2", "wr_way", tlb_wr_way, e_wway);
                check("R2", "wr_idx", tlb_wr_idx, e_widx);
                check("R2", "wr_vpn", tlb_wr_vpn, e_wvpn);
                check("R2", "wr_pid", tlb_wr_pid, e_wpid);
                check("R2", "wr_glob", tlb_wr_glob, e_wglob);
                check("R2", "wr_data", tlb_wr_data, e_wdata);
            end
            if (e_rd) begin
                check("R6", "rd_way", tlb_rd_way, e_rway);
                check("R6", "rd_idx", tlb_rd_idx, e_ridx);
            end
            e_wr = 0;
            e_rd = 0;
            creg_rsel = creg_rsel + 2'd1;
        end
    end

    task automatic bus_write(input int sel, input int unsigned v);
        int unsigned way;
        @(negedge clk);
        creg_we = 1'b1;
        creg_wsel = 2'(sel);
        creg_wdata = v;
        @(posedge clk);
        #1;
        case (sel)
            0: begin
                if ((e_ctrl_rb >> 18) & 1) begin
                    way = (e_ctrl_rb >> 20) % NW;
                    e_wr = 1;
                    e_wway = way;
                    e_widx = e_vpn_lw % NS;
                    e_wvpn = e_vpn_lw;
                    e_wpid = (e_ctrl_lw >> 4) & 8'hFF;
                    e_wglob = (v >> 24) & 1;
                    e_wdata = v & 24'hFFFFFF;
                    m_vpn[way][e_widx] = e_wvpn;
                    m_pid[way][e_widx] = e_wpid;
                    m_glob[way][e_widx] = e_wglob;
                    m_data[way][e_widx] = e_wdata;
                    e_ctrl_rb = (e_ctrl_rb & ~(32'h3 << 20)) | (((way + 1) % NW) << 20);
                end
            end
            1: begin
                e_ctrl_lw = v;
                if ((v >> 19) & 1) begin
                    e_rd = 1;
                    e_rway = (v >> 20) % NW;
                    e_ridx = e_vpn_lw % NS;
                end else begin
                    e_ctrl_rb = v;
                end
            end
            2: begin
                e_vpn_lw = (v >> 2) & 20'hFFFFF;
                e_ptr_rb = (v & ~(32'hFFFFF << 2)) | (e_ptr_rb & (32'hFFFFF << 2));
            end
            default: ;
        endcase
        @(negedge clk);
        creg_we = 1'b0;
    endtask

    // fetch one entry and fold the model's copy into the read-backs (R7, R8)
    task automatic fetch(input int way, input int unsigned ctrl_bits);
        int unsigned idx;
        idx = e_vpn_lw % NS;
        bus_write(1, ctrl_bits | (1 << 19) | ((way & 3) << 20));
        @(posedge clk);
        @(posedge clk);
        #1;
        e_attr_rb = (e_attr_rb & 32'hFE000000) | m_data[way][idx] | (m_glob[way][idx] << 24);
        e_ctrl_rb = (e_ctrl_lw & ~(32'hFF << 4)) | (m_pid[way][idx] << 4);
        e_ptr_rb = (e_ptr_rb & ~(32'hFFFFF << 2)) | (m_vpn[way][idx] << 2);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin
                s_vpn[w][s] = '0; s_pid[w][s] = '0; s_glob[w][s] = 1'b0; s_data[w][s] = '0;
                m_vpn[w][s] = 0; m_pid[w][s] = 0; m_glob[w][s] = 0; m_data[w][s] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state, all four selects
        for (int s = 0; s < 4; s++) begin
            creg_rsel = 2'(s);
            #0.5;
            check("R1", "reset readback", creg_rdata, 0);
        end
        check("R1", "reset pid", cur_pid, 0);
        check("R1", "reset requests", {tlb_wr_en, tlb_rd_en}, 0);
        run = 1;

        // R10 pointer write keeps the old read-back page number
        bus_write(2, 32'hABC0_0000 | (20'h12345 << 2) | 32'h3);
        // R9 control write with install enabled, identifier 5, way 0
        bus_write(1, (1 << 18) | (8'h05 << 4) | 32'h0000_0003);
        // R2 R3 R5 install four entries, way pointer wraps
        bus_write(0, 32'h7E00_0000 | (1 << 24) | 24'hC0ABCD);
        bus_write(2, 32'h0000_0000 | (20'h00042 << 2));
        bus_write(0, 24'h512345);
        bus_write(2, (20'hFFFFF << 2));
        bus_write(0, (1 << 24) | 24'h7FFFFF);
        bus_write(2, (20'h12345 << 2));
        bus_write(0, 24'h000001);
        // R4 install disabled: no request, way unchanged
        bus_write(1, (8'h07 << 4) | (2'd2 << 20));
        bus_write(0, 24'hFFFFFF);
        // R6 R7 R8 fetch the way-0 entry at page 0x12345 with identifier 9 written
        fetch(0, (8'h09 << 4));
        // fetch the way-1 entry at page 0x00042 (non-global)
        bus_write(2, 32'h5550_0000 | (20'h00042 << 2));
        fetch(1, 32'h0000_0100);
        // fetch an untouched slot: all entry fields zero
        bus_write(2, (20'h00007 << 2));
        fetch(3, 0);
        // R10 pointer write after a fetch keeps the fetched page number
        bus_write(2, 32'hFFFF_FFFF);
        // R9 control write without fetch reaches the read-back
        bus_write(1, 32'h0030_0AB0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        run = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule